// File: doc/BRIEF.md
# Table-Driven Microcoded State Sequencer

This block is a Moore state machine with no hand-written next-state logic. Its behaviour lives in two memories. The step table is indexed by the current state joined with a few branch-condition inputs. Each word it returns holds the successor state and one flag bit. The drive table is indexed by the state alone and returns a wide bus of parallel control outputs. Changing the machine only changes memory contents, so the path from state register to state register is always one memory read. That path stays the same however tangled the state graph is.

The default build has 8 state bits and 2 condition bits. That gives 256 states, a 4-way branch from each state, and a 1024-word step table. Setting 7 state bits and 3 condition bits keeps the same 1024-word space but gives 128 states with an 8-way branch. The drive table is 2^STATE_W words of 36 bits.

Both tables are filled through one load stream. The stream follows valid/ready rules. A word is taken on a rising clock edge only when `ld_valid` and `ld_ready` are both high. `ld_ready` is high exactly while the machine is held (`run_en` low). A source that sees `ld_ready` low must keep its word and wait, because nothing is taken while the machine runs. Control pins (`run_en`, `cond_in`, `rst`) are plain levels.

Top module: `ustore_sequencer`

## Requirements
- R1: A synchronous reset forces `state_o` to 0, `flag_o` to 0 and `ctrl_o` to all zeros on the edge where `rst` is high, whatever `run_en` shows.
- R2: On each edge with `run_en` high and `rst` low, `state_o` becomes bits [STATE_W-1:0] and `flag_o` becomes bit STATE_W of the step-table word at address {state_o, cond_in}, with the state in the upper bits and `cond_in` in the low COND_W bits.
- R3: On each edge with `run_en` low and `rst` low, `state_o` and `flag_o` keep their values.
- R4: Outside reset, `ctrl_o` after an edge equals the drive-table word for the `state_o` value seen before that edge, so the outputs trail the state by one cycle, whether running or held.
- R5: `ld_ready` equals the inverse of `run_en`.
- R6: A taken load word with `ld_sel` = 0 writes bits [STATE_W:0] of `ld_data` into the step table at `ld_addr`. With `ld_sel` = 1 it writes all OUT_W bits of `ld_data` into the drive table at `ld_addr[STATE_W-1:0]`. A read in the same edge sees the old word.
- R7: A load word offered while `run_en` is high writes nothing, so later steps and outputs still follow the earlier table contents.
- R8: From one state, each of the 2^COND_W condition values selects its own step-table word, so all branch targets can differ.
- R9: A reset asserted while `run_en` is high still returns the machine to state 0 on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| run_en | input | 1 | High: step each edge; low: hold and allow loads |
| cond_in | input | COND_W | Branch-condition bits, low part of the step address |
| ld_valid | input | 1 | Load word offered |
| ld_ready | output | 1 | Load word can be taken (machine held) |
| ld_sel | input | 1 | 0 selects the step table, 1 the drive table |
| ld_addr | input | STATE_W+COND_W | Load word address |
| ld_data | input | OUT_W | Load word data |
| state_o | output | STATE_W | Current state register |
| flag_o | output | 1 | Flag bit from the word that produced the current state |
| ctrl_o | output | OUT_W | Registered control outputs for the previous cycle's state |

## Verification
A wrong state value shows on `state_o` in the same cycle. Because every later address is formed from it, the whole following path of states and flags diverges from the model. `ctrl_o` then shows the wrong drive word exactly one cycle after the bad state appears, so a corrupted state register is visible on two separate port groups within two cycles. A load that lands while running, or at the wrong table or address, stays hidden until the machine next reads that word. The bench therefore revisits loaded words by running long random paths over fully loaded tables, and it also directs steps onto the exact word that a blocked write targeted.

// File: rtl/useq_pkg.sv
`timescale 1ns/1ps
package useq_pkg;
  // Which table a load word is aimed at
  typedef enum logic {
    TBL_STEP  = 1'b0,
    TBL_DRIVE = 1'b1
  } tbl_sel_e;
endpackage

// File: rtl/useq_load_port.sv
`timescale 1ns/1ps
// Load stream decode: accepts words only while the machine is held and
// steers each one to the step table or the drive table.
module useq_load_port
  import useq_pkg::*;
#(
  parameter int STATE_W = 8,
  parameter int COND_W  = 2,
  parameter int OUT_W   = 36,
  localparam int ADDR_W = STATE_W + COND_W,
  localparam int WORD_W = STATE_W + 1
) (
  input  logic              run_en,
  input  logic              ld_valid,
  input  logic              ld_sel,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [OUT_W-1:0]  ld_data,
  output logic              ld_ready,
  output logic              step_we,
  output logic [ADDR_W-1:0] step_waddr,
  output logic [WORD_W-1:0] step_wdata,
  output logic              drive_we,
  output logic [STATE_W-1:0] drive_waddr,
  output logic [OUT_W-1:0]  drive_wdata
);
  logic     take;
  tbl_sel_e dest;

  assign ld_ready = ~run_en;
  assign take     = ld_valid & ld_ready;
  assign dest     = tbl_sel_e'(ld_sel);

  assign step_we     = take && (dest == TBL_STEP);
  assign drive_we    = take && (dest == TBL_DRIVE);
  assign step_waddr  = ld_addr;
  assign drive_waddr = ld_addr[STATE_W-1:0];
  assign drive_wdata = ld_data;

  // The step word is taken from the low bits of the data bus; a narrow
  // output bus is zero-extended instead.
  generate
    if (OUT_W >= WORD_W) begin : g_slice
      assign step_wdata = ld_data[WORD_W-1:0];
    end else begin : g_pad
      assign step_wdata = {{(WORD_W-OUT_W){1'b0}}, ld_data};
    end
  endgenerate
endmodule

// File: rtl/useq_step_table.sv
`timescale 1ns/1ps
// Step table and state register: the registered read of word
// {state, cond} becomes the next state and flag.
module useq_step_table #(
  parameter int STATE_W = 8,
  parameter int COND_W  = 2,
  localparam int ADDR_W = STATE_W + COND_W,
  localparam int DEPTH  = 1 << ADDR_W,
  localparam int WORD_W = STATE_W + 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               run_en,
  input  logic [COND_W-1:0]  cond_i,
  input  logic               we_i,
  input  logic [ADDR_W-1:0]  waddr_i,
  input  logic [WORD_W-1:0]  wdata_i,
  output logic [STATE_W-1:0] state_o,
  output logic               flag_o
);
  logic [WORD_W-1:0]  mem [DEPTH];
  logic [WORD_W-1:0]  rd_word;
  logic [ADDR_W-1:0]  raddr;
  logic [STATE_W-1:0] state_q;
  logic               flag_q;

  always_ff @(posedge clk) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  assign raddr   = {state_q, cond_i};
  assign rd_word = mem[raddr];

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= '0;
      flag_q  <= 1'b0;
    end else if (run_en) begin
      state_q <= rd_word[STATE_W-1:0];
      flag_q  <= rd_word[STATE_W];
    end
  end

  assign state_o = state_q;
  assign flag_o  = flag_q;

  AST_STATE_CLEARED: assert property (@(posedge clk)
    rst |=> (state_q == '0) && !flag_q); // R1
  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    !run_en |=> $stable(state_q) && $stable(flag_q)); // R3
  AST_NO_LOAD_WHILE_RUN: assert property (@(posedge clk) disable iff (rst)
    we_i |-> !run_en); // R7
endmodule

// File: rtl/useq_drive_table.sv
`timescale 1ns/1ps
// Drive table: a second read port addressed by the state alone,
// registered, so the outputs trail the state by one cycle.
module useq_drive_table #(
  parameter int STATE_W = 8,
  parameter int OUT_W   = 36,
  localparam int DEPTH  = 1 << STATE_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [STATE_W-1:0] state_i,
  input  logic               we_i,
  input  logic [STATE_W-1:0] waddr_i,
  input  logic [OUT_W-1:0]   wdata_i,
  output logic [OUT_W-1:0]   ctrl_o
);
  logic [OUT_W-1:0] mem [DEPTH];
  logic [OUT_W-1:0] ctrl_q;

  always_ff @(posedge clk) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  always_ff @(posedge clk) begin
    if (rst) ctrl_q <= '0;
    else     ctrl_q <= mem[state_i];
  end

  assign ctrl_o = ctrl_q;

  AST_CTRL_CLEARED: assert property (@(posedge clk)
    rst |=> (ctrl_q == '0)); // R1
  AST_CTRL_HELD: assert property (@(posedge clk) disable iff (rst)
    $stable(state_i) && !we_i && !$past(we_i) && !$past(rst)
      |=> $stable(ctrl_q)); // R4
endmodule

// File: rtl/ustore_sequencer.sv
`timescale 1ns/1ps
// Top: table-driven Moore sequencer with a held-only load stream.
module ustore_sequencer #(
  parameter int STATE_W = 8,
  parameter int COND_W  = 2,
  parameter int OUT_W   = 36,
  localparam int ADDR_W = STATE_W + COND_W,
  localparam int WORD_W = STATE_W + 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               run_en,
  input  logic [COND_W-1:0]  cond_in,
  input  logic               ld_valid,
  output logic               ld_ready,
  input  logic               ld_sel,
  input  logic [ADDR_W-1:0]  ld_addr,
  input  logic [OUT_W-1:0]   ld_data,
  output logic [STATE_W-1:0] state_o,
  output logic               flag_o,
  output logic [OUT_W-1:0]   ctrl_o
);
  logic               step_we;
  logic [ADDR_W-1:0]  step_waddr;
  logic [WORD_W-1:0]  step_wdata;
  logic               drive_we;
  logic [STATE_W-1:0] drive_waddr;
  logic [OUT_W-1:0]   drive_wdata;
  logic [STATE_W-1:0] cur_state;

  useq_load_port #(.STATE_W(STATE_W), .COND_W(COND_W), .OUT_W(OUT_W)) u_load (
    .run_en      (run_en),
    .ld_valid    (ld_valid),
    .ld_sel      (ld_sel),
    .ld_addr     (ld_addr),
    .ld_data     (ld_data),
    .ld_ready    (ld_ready),
    .step_we     (step_we),
    .step_waddr  (step_waddr),
    .step_wdata  (step_wdata),
    .drive_we    (drive_we),
    .drive_waddr (drive_waddr),
    .drive_wdata (drive_wdata)
  );

  useq_step_table #(.STATE_W(STATE_W), .COND_W(COND_W)) u_step (
    .clk     (clk),
    .rst     (rst),
    .run_en  (run_en),
    .cond_i  (cond_in),
    .we_i    (step_we),
    .waddr_i (step_waddr),
    .wdata_i (step_wdata),
    .state_o (cur_state),
    .flag_o  (flag_o)
  );

  useq_drive_table #(.STATE_W(STATE_W), .OUT_W(OUT_W)) u_drive (
    .clk     (clk),
    .rst     (rst),
    .state_i (cur_state),
    .we_i    (drive_we),
    .waddr_i (drive_waddr),
    .wdata_i (drive_wdata),
    .ctrl_o  (ctrl_o)
  );

  assign state_o = cur_state;
endmodule

// File: tb/ustore_sequencer_bench.sv
`timescale 1ns/1ps
module ustore_sequencer_bench;
  localparam int STATE_W = 8;
  localparam int COND_W  = 2;
  localparam int OUT_W   = 36;
  localparam int ADDR_W  = STATE_W + COND_W;
  localparam int XD      = 1 << ADDR_W;
  localparam int OD      = 1 << STATE_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic run_en = 1'b0;
  logic [COND_W-1:0] cond_in = '0;
  logic ld_valid = 1'b0;
  logic ld_sel = 1'b0;
  logic [ADDR_W-1:0] ld_addr = '0;
  logic [OUT_W-1:0] ld_data = '0;
  logic ld_ready;
  logic [STATE_W-1:0] state_o;
  logic flag_o;
  logic [OUT_W-1:0] ctrl_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  ustore_sequencer u_ustore_sequencer (
    .clk(clk), .rst(rst), .run_en(run_en), .cond_in(cond_in),
    .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_sel(ld_sel),
    .ld_addr(ld_addr), .ld_data(ld_data),
    .state_o(state_o), .flag_o(flag_o), .ctrl_o(ctrl_o)
  );

  // Reference model built from the requirements
  logic [STATE_W:0]   m_x [XD];
  logic [OUT_W-1:0]   m_o [OD];
  logic [STATE_W-1:0] e_state = '0;
  logic               e_flag  = 1'b0;
  logic [OUT_W-1:0]   e_ctrl  = '0;

  always @(posedge clk) begin : model
    logic [STATE_W:0] rd;
    logic [OUT_W-1:0] od;
    rd = m_x[{e_state, cond_in}];
    od = m_o[e_state];
    if (rst) begin
      e_state = '0; e_flag = 1'b0; e_ctrl = '0;
    end else begin
      e_ctrl = od;
      if (run_en) begin
        e_state = rd[STATE_W-1:0];
        e_flag  = rd[STATE_W];
      end
    end
    if (ld_valid && !run_en) begin
      if (ld_sel) m_o[ld_addr[STATE_W-1:0]] = ld_data;
      else        m_x[ld_addr] = ld_data[STATE_W:0];
    end
  end

  function automatic logic [OUT_W-1:0] rnd_wide();
    return {$urandom(), $urandom()};
  endfunction

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic chk_all(input string st_tag);
    chk({st_tag, " state"}, 64'(state_o), 64'(e_state));
    chk({st_tag, " flag"}, 64'(flag_o), 64'(e_flag));
    chk("R4 ctrl", 64'(ctrl_o), 64'(e_ctrl));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #1ms;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [STATE_W-1:0] s0;
    logic [STATE_W:0]   old_w;
    bit prev_blocked;
    void'($urandom(32'd20240611));

    // Reset state: R1
    repeat (3) @(negedge clk);
    chk("R1 state", 64'(state_o), 64'd0);
    chk("R1 flag", 64'(flag_o), 64'd0);
    chk("R1 ctrl", 64'(ctrl_o), 64'd0);
    chk("R5 ready held", 64'(ld_ready), 64'd1);
    rst = 1'b0;

    // Fill both tables while held: R5, R6
    for (int i = 0; i < XD; i++) begin
      ld_valid = 1'b1; ld_sel = 1'b0; ld_addr = ADDR_W'(i);
      ld_data = rnd_wide();
      @(negedge clk);
    end
    for (int i = 0; i < OD; i++) begin
      ld_valid = 1'b1; ld_sel = 1'b1; ld_addr = ADDR_W'(i);
      ld_data = rnd_wide();
      @(negedge clk);
    end
    ld_valid = 1'b0;
    @(negedge clk);
    chk("R6 drive word 0", 64'(ctrl_o), 64'(m_o[0]));
    chk_all("R3");

    // Directed R6: rewrite drive word 0, visible after write edge + read edge
    ld_valid = 1'b1; ld_sel = 1'b1; ld_addr = '0; ld_data = 36'hA_5A5A_5A5A;
    @(negedge clk);
    ld_valid = 1'b0;
    @(negedge clk);
    chk("R6 drive rewrite", 64'(ctrl_o), 64'h0A_5A5A_5A5A);

    // Directed R8: distinct targets for each condition from state 0
    for (int c = 0; c < (1 << COND_W); c++) begin
      ld_valid = 1'b1; ld_sel = 1'b0; ld_addr = {STATE_W'(0), COND_W'(c)};
      ld_data = OUT_W'({1'(c), STATE_W'(8'h40 + c)});
      @(negedge clk);
    end
    ld_valid = 1'b0;
    for (int c = 0; c < (1 << COND_W); c++) begin
      rst = 1'b1; run_en = 1'b0;
      @(negedge clk);
      rst = 1'b0; run_en = 1'b1; cond_in = COND_W'(c);
      @(negedge clk);
      chk("R8 branch target", 64'(state_o), 64'(8'h40 + c));
      chk("R8 branch flag", 64'(flag_o), 64'(c & 1));
      chk_all("R2");
    end

    // Directed R9: reset wins over run
    run_en = 1'b1; rst = 1'b1;
    @(negedge clk);
    chk("R9 reset while running", 64'(state_o), 64'd0);
    chk("R9 ctrl cleared", 64'(ctrl_o), 64'd0);
    rst = 1'b0;

    // Directed R7: a blocked write aimed at the very word read next
    cond_in = 2'd1;
    s0 = e_state;
    old_w = m_x[{s0, cond_in}];
    ld_valid = 1'b1; ld_sel = 1'b0; ld_addr = {s0, cond_in};
    ld_data = OUT_W'(~old_w);
    #1 chk("R5 ready low while running", 64'(ld_ready), 64'd0);
    @(negedge clk);
    ld_valid = 1'b0;
    chk("R7 blocked write ignored", 64'(state_o), 64'(old_w[STATE_W-1:0]));
    run_en = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0; run_en = 1'b1; cond_in = 2'd1;
    @(negedge clk);
    chk("R7 table unchanged", 64'(state_o), 64'(m_x[{STATE_W'(0), 2'd1}] & 9'h0FF));

    // Constrained random run: R2, R3, R4, R5, R7
    prev_blocked = 1'b0;
    for (int n = 0; n < 4000; n++) begin
      cond_in  = COND_W'($urandom());
      run_en   = ($urandom() % 8) != 0;
      ld_valid = ($urandom() % 4) == 0;
      ld_sel   = 1'($urandom());
      ld_addr  = ADDR_W'($urandom());
      ld_data  = rnd_wide();
      #1 chk(run_en ? "R5 ready running" : "R5 ready held", 64'(ld_ready), 64'(!run_en));
      prev_blocked = ld_valid && run_en;
      @(negedge clk);
      chk_all(prev_blocked ? "R7" : (run_en ? "R2" : "R3"));
    end
    ld_valid = 1'b0;
    run_en = 1'b0;
    @(negedge clk);
    chk_all("R3");
    finish_run();
  end
endmodule